// File: doc/BRIEF.md
# Checksummed Six-Byte Frame Transmitter

This block sends a fixed-length frame of six bytes to a downstream byte transmitter, such as a UART transmit stage. A caller supplies five payload bytes together with a one-cycle start strobe. The block captures the payload and forms a check byte. The check byte is the XOR of all five payload bytes, folded onto the constant seed 0x5A. The block stores the check byte alongside the payload before the first byte leaves.

The frame goes out lowest byte first, followed by the check byte. Each byte is offered on a valid/ready handshake, and the block moves to the next byte only when the downstream side accepts the current one. The frame has no header or sync byte. While a frame is in flight the block holds busy high and ignores any further start strobe. A one-cycle done pulse marks the acceptance of the check byte.

Top module: `frame_tx_chk`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle with its byte index cleared. After that edge busy, tx_valid and done read 0.
- R2: A start pulse sampled high while idle is accepted. In the following cycle busy and tx_valid are 1 and tx_data carries payload byte 0.
- R3: The sixth byte sent equals 0x5A XOR byte0 XOR byte1 XOR byte2 XOR byte3 XOR byte4.
- R4: Bytes leave in the order 0, 1, 2, 3, 4, check. Payload byte k is payload[8k+7:8k].
- R5: While tx_valid is 1 and tx_ready is 0, the next cycle still shows tx_valid at 1 and the same tx_data. The index does not advance.
- R6: A start pulse sampled while busy is ignored. The bytes of the frame in flight come from the payload captured at the accepted start.
- R7: In the cycle after the check byte is accepted, done is 1 for exactly one cycle and busy and tx_valid are 0.
- R8: While idle, tx_ready has no effect: tx_valid stays 0 and done stays 0.
- R9: A start sampled in the cycle where done is 1 is accepted and launches a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| payload | input | 40 | Five payload bytes, byte k at bits 8k+7:8k |
| tx_data | output | 8 | Byte offered downstream |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Downstream accepts tx_data at this edge |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse after the check byte is accepted |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- byte 0 and busy appear one edge after an accepted start;
- each following byte appears one edge after the previous byte is accepted;
- done appears one edge after the check byte is accepted.

The bench drives inputs on the falling edge and samples one falling edge later, so every check lands exactly one register stage after the edge that caused it. Stall cycles are inserted between bytes from a per-vector mask. During a stall the bench compares the held byte on the next falling edge.

// File: rtl/fx_frame_pkg.sv
// Package: shared constants and state type for the frame transmitter.
// Assumes byte-wide frames; the seed width matches the byte width.
package fx_frame_pkg;
    localparam int unsigned FX_BYTE_W      = 8;
    localparam int unsigned FX_PAYLOAD_CNT = 5;
    localparam logic [FX_BYTE_W-1:0] FX_SEED = 8'h5A;

    typedef enum logic {
        FX_IDLE = 1'b0,
        FX_SEND = 1'b1
    } fx_state_e;
endpackage

// File: rtl/fx_check_gen.sv
// Module: fx_check_gen
// Folds all payload bytes onto a constant seed with XOR, combinationally.
// Assumes payload byte k sits at bits k*BYTE_W +: BYTE_W.
module fx_check_gen #(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned PAYLOAD_CNT = 5,
    parameter logic [BYTE_W-1:0] SEED  = 8'h5A
) (
    input  logic [BYTE_W*PAYLOAD_CNT-1:0] payload_i,
    output logic [BYTE_W-1:0]             check_o
);
    logic [BYTE_W-1:0] chain [PAYLOAD_CNT+1];

    assign chain[0] = SEED;

    // XOR chain: one stage per payload byte
    for (genvar k = 0; k < PAYLOAD_CNT; k++) begin : g_fold
        assign chain[k+1] = chain[k] ^ payload_i[k*BYTE_W +: BYTE_W];
    end

    assign check_o = chain[PAYLOAD_CNT];
endmodule

// File: rtl/fx_frame_store.sv
// Module: fx_frame_store
// Holds the payload and check byte of the current frame and selects one by index.
// Assumes load_i is raised only on an accepted start.
module fx_frame_store #(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned PAYLOAD_CNT = 5,
    localparam int unsigned FRAME_LEN  = PAYLOAD_CNT + 1,
    localparam int unsigned IDX_W      = $clog2(FRAME_LEN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [BYTE_W*PAYLOAD_CNT-1:0] payload_i,
    input  logic [BYTE_W-1:0]             check_i,
    input  logic [IDX_W-1:0]              sel_i,
    output logic [BYTE_W-1:0]             byte_o
);
    logic [BYTE_W-1:0] slot_q [FRAME_LEN];

    for (genvar k = 0; k < FRAME_LEN; k++) begin : g_slot
        // Capture one frame slot on load: payload bytes, or the check byte in the last slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[k] <= '0;
            end else if (load_i) begin
                if (k < PAYLOAD_CNT) slot_q[k] <= payload_i[k*BYTE_W +: BYTE_W];
                else                 slot_q[k] <= check_i;
            end
        end
    end

    assign byte_o = slot_q[sel_i];
endmodule

// File: rtl/fx_seq.sv
// Module: fx_seq
// Steps a byte index through one frame on a valid/ready handshake.
// Assumes the downstream side samples valid and ready on the same rising edge.
module fx_seq
    import fx_frame_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 6,
    localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ready_i,
    output logic             load_o,
    output logic             valid_o,
    output logic             done_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    fx_state_e        state_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;

    // State, index and done pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FX_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                FX_IDLE: if (start_i) begin
                    state_q <= FX_SEND;
                    idx_q   <= '0;
                end
                FX_SEND: if (ready_i) begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= FX_IDLE;
                        idx_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: state_q <= FX_IDLE;
            endcase
        end
    end

    assign load_o  = (state_q == FX_IDLE) && start_i;
    assign valid_o = (state_q == FX_SEND);
    assign done_o  = done_q;
    assign idx_o   = idx_q;

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_o) |=> (valid_o && idx_o == '0));
    // R5
    stall_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(idx_o)));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> (!valid_o && idx_o == '0));
endmodule

// File: rtl/frame_tx_chk.sv
// Module: frame_tx_chk
// Sends five payload bytes plus a seeded XOR check byte as one six-byte frame.
// Assumes a downstream byte transmitter with a valid/ready handshake.
module frame_tx_chk
    import fx_frame_pkg::*;
#(
    parameter int unsigned BYTE_W      = FX_BYTE_W,
    parameter int unsigned PAYLOAD_CNT = FX_PAYLOAD_CNT,
    parameter logic [BYTE_W-1:0] SEED  = FX_SEED,
    localparam int unsigned FRAME_LEN  = PAYLOAD_CNT + 1,
    localparam int unsigned IDX_W      = $clog2(FRAME_LEN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [BYTE_W*PAYLOAD_CNT-1:0] payload,
    output logic [BYTE_W-1:0]             tx_data,
    output logic                          tx_valid,
    input  logic                          tx_ready,
    output logic                          busy,
    output logic                          done
);
    logic [BYTE_W-1:0] check_w;
    logic              load_w;
    logic [IDX_W-1:0]  idx_w;

    fx_check_gen #(
        .BYTE_W     (BYTE_W),
        .PAYLOAD_CNT(PAYLOAD_CNT),
        .SEED       (SEED)
    ) u_check (
        .payload_i(payload),
        .check_o  (check_w)
    );

    fx_seq #(
        .FRAME_LEN(FRAME_LEN)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .ready_i(tx_ready),
        .load_o (load_w),
        .valid_o(tx_valid),
        .done_o (done),
        .idx_o  (idx_w)
    );

    fx_frame_store #(
        .BYTE_W     (BYTE_W),
        .PAYLOAD_CNT(PAYLOAD_CNT)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .payload_i(payload),
        .check_i  (check_w),
        .sel_i    (idx_w),
        .byte_o   (tx_data)
    );

    assign busy = tx_valid;

    // R5
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !tx_valid));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));
endmodule

// File: tb/frame_tx_chk_bench.sv
module frame_tx_chk_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [39:0] payload = '0;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid, busy, done;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    frame_tx_chk u_frame_tx_chk (
        .clk(clk), .rst_n(rst_n), .start(start), .payload(payload),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .busy(busy), .done(done)
    );

    localparam int NV = 5;
    localparam logic [39:0] VEC_PAY [NV] = '{
        40'h00_00_00_00_00, 40'hFF_FF_FF_FF_FF, 40'h05_04_03_02_01,
        40'h0F_C3_3C_5A_A5, 40'h5A_00_00_00_00 };
    localparam logic [5:0] VEC_STALL [NV] = '{
        6'b000000, 6'b111111, 6'b100001, 6'b010100, 6'b001010 };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [39:0] p, input int k);
        logic [7:0] c;
        if (k < 5) return p[k*8 +: 8];
        c = 8'h5A;
        for (int j = 0; j < 5; j++) c = c ^ p[j*8 +: 8];
        return c;
    endfunction

    // Launch with p, then walk six bytes; mid_start injects a busy start with alt payload (R6)
    task automatic send_frame(input logic [39:0] p, input logic [5:0] stall, input bit mid_start);
        @(negedge clk);
        payload = p; start = 1'b1; tx_ready = 1'b0;
        @(negedge clk);
        start = 1'b0; payload = ~p;
        chk("R2 busy", {7'd0, busy}, 8'd1);
        chk("R2 valid", {7'd0, tx_valid}, 8'd1);
        for (int k = 0; k < 6; k++) begin
            if (stall[k]) begin
                tx_ready = 1'b0;
                if (mid_start && k == 2) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk("R5 held valid", {7'd0, tx_valid}, 8'd1);
                chk("R5 held data", tx_data, exp_byte(p, k));
            end
            chk(k == 5 ? "R3 check byte" : (mid_start ? "R6 frame byte" : "R4 frame byte"),
                tx_data, exp_byte(p, k));
            chk("R7 no early done", {7'd0, done}, 8'd0);
            tx_ready = 1'b1;
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R7 done pulse", {7'd0, done}, 8'd1);
        chk("R7 busy low", {7'd0, busy}, 8'd0);
        chk("R7 valid low", {7'd0, tx_valid}, 8'd0);
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", {7'd0, busy}, 8'd0);
        chk("R1 valid", {7'd0, tx_valid}, 8'd0);
        chk("R1 done", {7'd0, done}, 8'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) send_frame(VEC_PAY[v], VEC_STALL[v], 1'b0);

        // R7 done lasts one cycle
        @(negedge clk);
        chk("R7 done one cycle", {7'd0, done}, 8'd0);

        // R8 ready while idle
        tx_ready = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R8 idle valid", {7'd0, tx_valid}, 8'd0);
            chk("R8 idle done", {7'd0, done}, 8'd0);
        end
        tx_ready = 1'b0;

        // R6 start while busy ignored
        send_frame(40'h11_22_33_44_55, 6'b000100, 1'b1);

        // R9 back-to-back: start in the done cycle
        send_frame(40'h12_34_56_78_9A, 6'b000000, 1'b0);
        payload = 40'hCA_FE_BE_EF_77; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 relaunch busy", {7'd0, busy}, 8'd1);
        chk("R9 relaunch byte0", tx_data, 8'h77);

        // R1 reset mid-frame
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset busy", {7'd0, busy}, 8'd0);
        chk("R1 reset valid", {7'd0, tx_valid}, 8'd0);
        send_frame(40'hA1_B2_C3_D4_E5, 6'b000000, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule